// File: doc/BRIEF.md
# Ping-Pong Management Command Responder

This block services management commands one at a time and posts each result into one of two response slots, used in turn. Software writes a command verb and a pool number into the command slot. Bit 7 of the verb is a valid bit that software inverts for every new command. The block starts a command only when that bit differs from the bit of the last command it serviced. It then works for a fixed number of cycles and writes the result into the slot chosen by the valid bit. While a command is in flight, the verb of its slot reads as zero, so software can poll one byte to see when the result is ready.

The two commands are acquire and query. Acquire removes up to eight buffer addresses from one of the per-pool last-in-first-out stacks. Query returns a stub response. The stacks share one buffer store. A release path outside the block fills them through a push port, one address per cycle.

Top module: `mcr_responder`

## Requirements
- R1: After reset, both slot verbs read 0x00, `push_overflow` is 0, every pool is empty and the valid-bit tracker is 0.
- R2: A command write is started only when `cmd_verb[7]` differs from the tracker. A write whose bit equals the tracker changes neither slot.
- R3: A command whose valid bit is 1 completes into slot 0, and one whose valid bit is 0 completes into slot 1. The other slot is left unchanged.
- R4: From the cycle after the command is accepted, the target slot verb reads 0x00. The result appears exactly `LAT` clock edges after the accepting edge.
- R5: An acquire (verb bits 6:4 = 3'b001, bits 3:0 = N, with 1 ≤ N ≤ 8) on a pool holding at least N entries responds with verb {vbit, 3'b001, N}. Payload entries 0..N-1 hold the most recently pushed addresses, newest first. The remaining entries are zero. The pool number is echoed, zero-extended, in the slot pool byte.
- R6: An acquire on a pool holding fewer than N entries responds with count 0 and an all-zero payload, and removes nothing.
- R7: A query (bits 6:4 = 3'b100) responds with verb {vbit, 3'b100, 4'b0000} and leaves the pools untouched.
- R8: Any other code, or an acquire with N = 0 or N > 8, responds with verb {vbit, 3'b110, 4'b0000} and removes nothing.
- R9: A push stacks its address onto its pool. A push to a pool already holding `DEPTH` entries is dropped and sets the sticky `push_overflow`.
- R10: Command writes that arrive while a command is in flight are discarded and do not update the tracker.
- R11: When a push and an acquire on the same pool take effect on the same edge, the pop is applied first and the pushed address then sits on top.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command slot write strobe |
| cmd_verb | input | 8 | Command verb: valid bit, code, count |
| cmd_pool | input | POOL_W | Target pool number |
| push_en | input | 1 | Release push strobe |
| push_pool | input | POOL_W | Pool receiving the pushed address |
| push_addr | input | ADDR_W | Buffer address pushed |
| slot0_verb | output | 8 | Response verb of slot 0 |
| slot1_verb | output | 8 | Response verb of slot 1 |
| slot0_pool | output | 8 | Pool echo of slot 0 |
| slot1_pool | output | 8 | Pool echo of slot 1 |
| rd_slot | input | 1 | Slot selected for payload read |
| rd_idx | input | 3 | Payload entry selected |
| rd_addr | output | ADDR_W | Selected payload entry |
| push_overflow | output | 1 | Sticky: a push was dropped |

## Verification
The assertions check properties that must hold on every cycle. The target slot must read zero right after acceptance. A repeated valid bit on an idle block must change no slot, and the two slot verbs never change on the same edge. A completed verb is never zero. No pop may exceed a pool's stock, no pool may exceed its depth, and the overflow flag must stay set once raised. Some behaviours only the bench scenarios can show: the exact result values, newest-first payload order, the latency, rejection of malformed verbs, discarding of writes made while busy, and the ordering when a pop and a push land on the same edge.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
    localparam int NBUF  = 8;
    localparam int CNT_W = 4;
    localparam int IDX_W = $clog2(NBUF);

    typedef enum logic [2:0] {
        CODE_ACQ = 3'b001,
        CODE_QRY = 3'b100,
        CODE_BAD = 3'b110,
        CODE_ECC = 3'b111
    } code_e;

    typedef enum logic [1:0] {
        K_ACQ = 2'd0,
        K_QRY = 2'd1,
        K_BAD = 2'd2
    } kind_e;
endpackage

// File: rtl/mcr_decode.sv
module mcr_decode
    import mcr_pkg::*;
(
    input  logic [6:0]       body,
    output kind_e            kind,
    output logic [CNT_W-1:0] count
);
    always_comb begin
        count = body[CNT_W-1:0];
        case (body[6:4])
            CODE_ACQ: kind = (count >= CNT_W'(1) && count <= CNT_W'(NBUF)) ? K_ACQ : K_BAD;
            CODE_QRY: kind = K_QRY;
            default:  kind = K_BAD;
        endcase
    end
endmodule

// File: rtl/mcr_pool_store.sv
module mcr_pool_store
    import mcr_pkg::*;
#(
    parameter int POOL_W = 6,
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push_en,
    input  logic [POOL_W-1:0]  push_pool,
    input  logic [ADDR_W-1:0]  push_addr,
    input  logic               pop_en,
    input  logic [POOL_W-1:0]  pop_pool,
    input  logic [CNT_W-1:0]   pop_n,
    output logic [$clog2(DEPTH+1)-1:0] sel_fill,
    output logic [ADDR_W-1:0]  peek [NBUF],
    output logic               ovf
);
    localparam int NPOOL   = 1 << POOL_W;
    localparam int FILL_W  = $clog2(DEPTH + 1);
    localparam int DEPTH_W = $clog2(DEPTH);

    logic [ADDR_W-1:0] mem_q  [NPOOL][DEPTH];
    logic [ADDR_W-1:0] mem_d  [NPOOL][DEPTH];
    logic [FILL_W-1:0] fill_q [NPOOL];
    logic [FILL_W-1:0] fill_d [NPOOL];
    logic              ovf_q, ovf_d;
    logic [FILL_W-1:0] after_pop, base;

    always_comb begin
        mem_d     = mem_q;
        fill_d    = fill_q;
        ovf_d     = ovf_q;
        after_pop = fill_q[pop_pool];
        base      = fill_q[push_pool];
        if (pop_en) begin
            after_pop        = fill_q[pop_pool] - FILL_W'(pop_n);
            fill_d[pop_pool] = after_pop;
        end
        if (push_en) begin
            if (pop_en && push_pool == pop_pool) base = after_pop;
            if (int'(base) < DEPTH) begin
                mem_d[push_pool][base[DEPTH_W-1:0]] = push_addr;
                fill_d[push_pool] = base + 1'b1;
            end else begin
                ovf_d = 1'b1;
            end
        end
    end

    always_comb begin
        sel_fill = fill_q[pop_pool];
        for (int i = 0; i < NBUF; i++) begin
            peek[i] = '0;
            if (i < int'(sel_fill))
                peek[i] = mem_q[pop_pool][DEPTH_W'(int'(sel_fill) - 1 - i)];
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NPOOL; p++) fill_q[p] <= '0;
            ovf_q <= 1'b0;
        end else begin
            fill_q <= fill_d;
            ovf_q  <= ovf_d;
        end
    end

    assign ovf = ovf_q;

    p_pop_in_stock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pop_en |-> int'(fill_q[pop_pool]) >= int'(pop_n));

    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q);

    for (genvar g = 0; g < NPOOL; g++) begin : g_bound
        p_fill_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
            int'(fill_q[g]) <= DEPTH);
    end
endmodule

// File: rtl/mcr_resp_slots.sv
module mcr_resp_slots
    import mcr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_en,
    input  logic              clr_slot,
    input  logic              wr_en,
    input  logic              wr_slot,
    input  logic [7:0]        wr_verb,
    input  logic [7:0]        wr_pool,
    input  logic [ADDR_W-1:0] wr_bufs [NBUF],
    input  logic              rd_slot,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [7:0]        verb0,
    output logic [7:0]        verb1,
    output logic [7:0]        pool0,
    output logic [7:0]        pool1,
    output logic [ADDR_W-1:0] rd_data
);
    logic [7:0]        verb_q [2];
    logic [7:0]        verb_d [2];
    logic [7:0]        pool_q [2];
    logic [7:0]        pool_d [2];
    logic [ADDR_W-1:0] buf_q  [2][NBUF];
    logic [ADDR_W-1:0] buf_d  [2][NBUF];

    always_comb begin
        verb_d = verb_q;
        pool_d = pool_q;
        buf_d  = buf_q;
        if (clr_en) verb_d[clr_slot] = 8'h00;
        if (wr_en) begin
            verb_d[wr_slot] = wr_verb;
            pool_d[wr_slot] = wr_pool;
            buf_d[wr_slot]  = wr_bufs;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < 2; s++) begin
                verb_q[s] <= '0;
                pool_q[s] <= '0;
                for (int i = 0; i < NBUF; i++) buf_q[s][i] <= '0;
            end
        end else begin
            verb_q <= verb_d;
            pool_q <= pool_d;
            buf_q  <= buf_d;
        end
    end

    assign verb0   = verb_q[0];
    assign verb1   = verb_q[1];
    assign pool0   = pool_q[0];
    assign pool1   = pool_q[1];
    assign rd_data = buf_q[rd_slot][rd_idx];

    p_done_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_verb != 8'h00);

    p_clear_write_apart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr_en && wr_en));

    p_one_slot_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(verb_q[0]) |-> $stable(verb_q[1]));
endmodule

// File: rtl/mcr_responder.sv
module mcr_responder
    import mcr_pkg::*;
#(
    parameter int POOL_W = 6,
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 32,
    parameter int LAT    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [7:0]        cmd_verb,
    input  logic [POOL_W-1:0] cmd_pool,
    input  logic              push_en,
    input  logic [POOL_W-1:0] push_pool,
    input  logic [ADDR_W-1:0] push_addr,
    output logic [7:0]        slot0_verb,
    output logic [7:0]        slot1_verb,
    output logic [7:0]        slot0_pool,
    output logic [7:0]        slot1_pool,
    input  logic              rd_slot,
    input  logic [2:0]        rd_idx,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              push_overflow
);
    localparam int FILL_W = $clog2(DEPTH + 1);
    localparam int LAT_W  = (LAT > 1) ? $clog2(LAT) : 1;

    typedef struct packed {
        logic              busy;
        logic              seen;
        logic              vbit;
        kind_e             kind;
        logic [CNT_W-1:0]  n;
        logic [POOL_W-1:0] pool;
        logic [LAT_W-1:0]  lat;
    } ctl_t;

    ctl_t c_q, c_d;

    kind_e             dec_kind;
    logic [CNT_W-1:0]  dec_n;
    logic              accept, done, stock_ok, pop_en;
    logic [FILL_W-1:0] sel_fill;
    logic [ADDR_W-1:0] peek    [NBUF];
    logic [ADDR_W-1:0] wr_bufs [NBUF];
    logic [7:0]        wr_verb;

    mcr_decode u_dec (
        .body  (cmd_verb[6:0]),
        .kind  (dec_kind),
        .count (dec_n)
    );

    always_comb begin
        c_d      = c_q;
        accept   = cmd_we && !c_q.busy && (cmd_verb[7] != c_q.seen);
        done     = c_q.busy && (c_q.lat == '0);
        if (accept) begin
            c_d.busy = 1'b1;
            c_d.seen = cmd_verb[7];
            c_d.vbit = cmd_verb[7];
            c_d.kind = dec_kind;
            c_d.n    = dec_n;
            c_d.pool = cmd_pool;
            c_d.lat  = LAT_W'(LAT - 1);
        end else if (c_q.busy) begin
            if (done) c_d.busy = 1'b0;
            else      c_d.lat  = c_q.lat - 1'b1;
        end

        stock_ok = int'(sel_fill) >= int'(c_q.n);
        pop_en   = done && (c_q.kind == K_ACQ) && stock_ok;

        case (c_q.kind)
            K_ACQ:   wr_verb = {c_q.vbit, CODE_ACQ, stock_ok ? c_q.n : CNT_W'(0)};
            K_QRY:   wr_verb = {c_q.vbit, CODE_QRY, 4'b0000};
            default: wr_verb = {c_q.vbit, CODE_BAD, 4'b0000};
        endcase

        for (int i = 0; i < NBUF; i++)
            wr_bufs[i] = (pop_en && i < int'(c_q.n)) ? peek[i] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    mcr_pool_store #(
        .POOL_W (POOL_W),
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_en   (push_en),
        .push_pool (push_pool),
        .push_addr (push_addr),
        .pop_en    (pop_en),
        .pop_pool  (c_q.pool),
        .pop_n     (c_q.n),
        .sel_fill  (sel_fill),
        .peek      (peek),
        .ovf       (push_overflow)
    );

    mcr_resp_slots #(
        .ADDR_W (ADDR_W)
    ) u_slots (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_en   (accept),
        .clr_slot (~cmd_verb[7]),
        .wr_en    (done),
        .wr_slot  (~c_q.vbit),
        .wr_verb  (wr_verb),
        .wr_pool  (8'(c_q.pool)),
        .wr_bufs  (wr_bufs),
        .rd_slot  (rd_slot),
        .rd_idx   (rd_idx),
        .verb0    (slot0_verb),
        .verb1    (slot1_verb),
        .pool0    (slot0_pool),
        .pool1    (slot1_pool),
        .rd_data  (rd_addr)
    );

    p_pending_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (($past(cmd_verb[7]) ? slot0_verb : slot1_verb) == 8'h00));

    p_same_bit_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !c_q.busy && cmd_verb[7] == c_q.seen)
        |=> ($stable(slot0_verb) && $stable(slot1_verb)));
endmodule

// File: tb/tb_mcr_responder.sv
`timescale 1ns/1ps
module tb_mcr_responder;
    localparam int POOL_W = 6;
    localparam int DEPTH  = 4;
    localparam int ADDR_W = 32;
    localparam int LAT    = 3;
    localparam int NV     = 13;

    typedef struct packed {
        logic        is_cmd;
        logic [6:0]  body;
        logic [5:0]  pool;
        logic [31:0] addr;
        logic [7:0]  exp;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{1'b0, 7'h00, 6'd1, 32'hA100, 8'h00},
        '{1'b0, 7'h00, 6'd1, 32'hA101, 8'h00},
        '{1'b0, 7'h00, 6'd1, 32'hA102, 8'h00},
        '{1'b0, 7'h00, 6'd2, 32'hA200, 8'h00},
        '{1'b1, 7'h12, 6'd1, 32'h0,    8'h12},
        '{1'b1, 7'h12, 6'd1, 32'h0,    8'h10},
        '{1'b1, 7'h11, 6'd1, 32'h0,    8'h11},
        '{1'b1, 7'h40, 6'd5, 32'h0,    8'h40},
        '{1'b1, 7'h21, 6'd2, 32'h0,    8'h60},
        '{1'b1, 7'h10, 6'd2, 32'h0,    8'h60},
        '{1'b1, 7'h19, 6'd2, 32'h0,    8'h60},
        '{1'b1, 7'h11, 6'd2, 32'h0,    8'h11},
        '{1'b1, 7'h11, 6'd1, 32'h0,    8'h10}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_we = 1'b0;
    logic [7:0]        cmd_verb = '0;
    logic [POOL_W-1:0] cmd_pool = '0;
    logic              push_en = 1'b0;
    logic [POOL_W-1:0] push_pool = '0;
    logic [ADDR_W-1:0] push_addr = '0;
    logic [7:0]        slot0_verb, slot1_verb, slot0_pool, slot1_pool;
    logic              rd_slot = 1'b0;
    logic [2:0]        rd_idx = '0;
    logic [ADDR_W-1:0] rd_addr;
    logic              push_overflow;

    int   n_run = 0;
    int   n_fail = 0;
    logic vb_last = 1'b0;

    always #10 clk = ~clk;

    mcr_responder #(.POOL_W(POOL_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .LAT(LAT)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_verb(cmd_verb), .cmd_pool(cmd_pool),
        .push_en(push_en), .push_pool(push_pool), .push_addr(push_addr),
        .slot0_verb(slot0_verb), .slot1_verb(slot1_verb),
        .slot0_pool(slot0_pool), .slot1_pool(slot1_pool),
        .rd_slot(rd_slot), .rd_idx(rd_idx), .rd_addr(rd_addr), .push_overflow(push_overflow)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] verb_of(input logic b);
        return b ? slot0_verb : slot1_verb;
    endfunction

    function automatic logic [7:0] pool_of(input logic b);
        return b ? slot0_pool : slot1_pool;
    endfunction

    task automatic do_push(input logic [5:0] p, input logic [31:0] a);
        @(negedge clk);
        push_en = 1'b1; push_pool = p; push_addr = a;
        @(posedge clk);
        @(negedge clk);
        push_en = 1'b0;
    endtask

    // drives a command with the given valid bit; returns at the negedge after the accepting edge
    task automatic send(input logic b, input logic [6:0] body, input logic [5:0] p);
        @(negedge clk);
        cmd_we = 1'b1; cmd_verb = {b, body}; cmd_pool = p;
        @(posedge clk);
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic wait_done();
        repeat (LAT) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run(input logic [6:0] body, input logic [5:0] p, output logic b);
        b = ~vb_last;
        vb_last = b;
        send(b, body, p);
        wait_done();
    endtask

    task automatic rd(input logic s, input int idx, output logic [31:0] d);
        rd_slot = s; rd_idx = 3'(idx);
        #1;
        d = rd_addr;
    endtask

    function automatic string tag_for(input logic [7:0] e);
        if (e[6:4] == 3'b110) return "R8";
        if (e[6:4] == 3'b100) return "R7";
        if (e[3:0] == 4'd0)   return "R6";
        return "R5";
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        logic        b, b2;
        logic [7:0]  other;
        logic [31:0] d;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 slot0 verb", 64'(slot0_verb), 64'h0);
        chk("R1 slot1 verb", 64'(slot1_verb), 64'h0);
        chk("R1 overflow", 64'(push_overflow), 64'h0);

        // table walk: R3 R5 R6 R7 R8
        for (int k = 0; k < NV; k++) begin
            if (!VEC[k].is_cmd) begin
                do_push(VEC[k].pool, VEC[k].addr);
            end else begin
                other = verb_of(vb_last);
                run(VEC[k].body, VEC[k].pool, b);
                chk(tag_for(VEC[k].exp), 64'(verb_of(b)), 64'({b, VEC[k].exp[6:0]}));
                chk("R5 pool echo", 64'(pool_of(b)), 64'(VEC[k].pool));
                chk("R3 other slot kept", 64'(verb_of(~b)), 64'(other));
                if (k == 4) chk("R3 first command lands in slot 0", 64'(b), 64'h1);
            end
        end
        chk("R9 no overflow yet", 64'(push_overflow), 64'h0);

        // R4 pending slot reads zero, result after exactly LAT edges
        b = ~vb_last; vb_last = b;
        send(b, 7'h11, 6'd20);
        chk("R4 pending verb zero", 64'(verb_of(b)), 64'h0);
        repeat (LAT - 1) @(posedge clk);
        @(negedge clk);
        chk("R4 still zero before latency", 64'(verb_of(b)), 64'h0);
        @(posedge clk);
        @(negedge clk);
        chk("R4 result at latency", 64'(verb_of(b)), 64'({b, 7'h10}));

        // R2 repeated valid bit is ignored
        other = slot0_verb; d = 32'(slot1_verb);
        send(vb_last, 7'h40, 6'd5);
        wait_done();
        @(negedge clk);
        chk("R2 slot0 unchanged", 64'(slot0_verb), 64'(other));
        chk("R2 slot1 unchanged", 64'(slot1_verb), 64'(d[7:0]));

        // R10 write while busy is discarded
        b = ~vb_last; vb_last = b;
        other = verb_of(~b);
        send(b, 7'h11, 6'd21);
        @(negedge clk);
        cmd_we = 1'b1; cmd_verb = {~b, 7'h40}; cmd_pool = 6'd5;
        @(posedge clk);
        @(negedge clk);
        cmd_we = 1'b0;
        repeat (LAT + 2) @(posedge clk);
        @(negedge clk);
        chk("R10 first result", 64'(verb_of(b)), 64'({b, 7'h10}));
        chk("R10 busy write discarded", 64'(verb_of(~b)), 64'(other));
        run(7'h40, 6'd5, b2);
        chk("R10 tracker untouched, next bit runs", 64'(verb_of(b2)), 64'({b2, 7'h40}));

        // R9 overflow on a full pool
        for (int i = 0; i < DEPTH + 1; i++) do_push(6'd7, 32'hD000 + 32'(i));
        chk("R9 overflow set", 64'(push_overflow), 64'h1);
        run(7'h14, 6'd7, b);
        chk("R9 full pool acquire", 64'(verb_of(b)), 64'({b, 7'h14}));
        rd(~b, 0, d);
        chk("R9 top is last kept push", 64'(d), 64'hD003);
        rd(~b, 3, d);
        chk("R9 bottom is first push", 64'(d), 64'hD000);
        chk("R9 overflow sticky", 64'(push_overflow), 64'h1);

        // R5 newest-first payload, zero tail
        do_push(6'd3, 32'hB000);
        do_push(6'd3, 32'hB001);
        do_push(6'd3, 32'hB002);
        run(7'h13, 6'd3, b);
        chk("R5 verb", 64'(verb_of(b)), 64'({b, 7'h13}));
        rd(~b, 0, d); chk("R5 entry0", 64'(d), 64'hB002);
        rd(~b, 1, d); chk("R5 entry1", 64'(d), 64'hB001);
        rd(~b, 2, d); chk("R5 entry2", 64'(d), 64'hB000);
        rd(~b, 3, d); chk("R5 entry3 zero", 64'(d), 64'h0);
        rd(~b, 7, d); chk("R5 entry7 zero", 64'(d), 64'h0);

        // R6 short pool: payload stays zero
        do_push(6'd4, 32'hC400);
        run(7'h12, 6'd4, b);
        chk("R6 count zero", 64'(verb_of(b)), 64'({b, 7'h10}));
        rd(~b, 0, d); chk("R6 payload zero", 64'(d), 64'h0);
        run(7'h11, 6'd4, b);
        chk("R6 nothing removed", 64'(verb_of(b)), 64'({b, 7'h11}));

        // R11 push and pop land on the same edge
        do_push(6'd9, 32'hC000);
        do_push(6'd9, 32'hC001);
        b = ~vb_last; vb_last = b;
        send(b, 7'h12, 6'd9);
        repeat (LAT - 1) @(posedge clk);
        @(negedge clk);
        push_en = 1'b1; push_pool = 6'd9; push_addr = 32'hC002;
        @(posedge clk);
        @(negedge clk);
        push_en = 1'b0;
        chk("R11 pop result", 64'(verb_of(b)), 64'({b, 7'h12}));
        rd(~b, 0, d); chk("R11 popped newest", 64'(d), 64'hC001);
        run(7'h11, 6'd9, b);
        chk("R11 pushed entry kept", 64'(verb_of(b)), 64'({b, 7'h11}));
        rd(~b, 0, d); chk("R11 pushed entry on top", 64'(d), 64'hC002);
        run(7'h11, 6'd9, b);
        chk("R11 pool now empty", 64'(verb_of(b)), 64'({b, 7'h10}));

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule